// File: doc/BRIEF.md
# Soft Reset Sequencer for a Multichannel Serial Controller

This block performs the device-wide soft reset of a multichannel serial communications controller. A reset can come from the host bus reset or from a host write of the soft-reset code into the service request register. When it fires, the block returns its configuration and status registers to their reset state in one host clock. A few fields are kept and two mask bits are forced to 1. Every channel of every channel group is dropped, in both the transmit and the receive direction.

The channel groups run on their own transmit and receive serial clocks, and those clocks may be stopped when the reset is requested. Each group and direction is therefore a separate lane. A lane holds a pending flag that crosses into its serial clock domain. The flag clears only after that serial clock has produced two edges while it can see the request. While a lane is pending, requests to activate its channels are dropped. The reset is never acknowledged: it posts nothing to the interrupt queue. Another module posts interrupts to that queue, and this block tracks the queue's write position.

Top module: `soft_reset_seq`

## Requirements
- R1: While `rst_n` is low and right after it rises, every register reads 0, except GRPCFG (address 2), which reads 0x30. All bits of `tx_pend` and `rx_pend` are 1, `all_idle` is 0, `iq_idx` is 0, and every channel reads inactive.
- R2: A write to SVCREQ (address 6) whose bits [4:0] equal 0x11 starts a soft reset. Afterwards GCFG (address 0) reads 0 in bits [31:2] and keeps its bits [1:0] (the port map).
- R3: ISTAT (address 1) holds the posted-interrupt count in bits [15:0], the next write index in bits [16+IDXW-1:16], and a sticky wrap flag in bit 31. It reads 0 after a soft reset, and `iq_idx` returns to 0.
- R4: After a soft reset, GRPCFG reads exactly 0x30. Bit 4 (change-of-frame-alignment mask) and bit 5 (out-of-frame mask) are 1. Bit 0 (transmit enable), bit 1 (receive enable) and all other bits are 0.
- R5: A soft reset leaves IQPTR (address 7) and IQLEN (address 8) unchanged.
- R6: After a soft reset, PORTCFG (3), MEMPROT (4), MSGLEN (5) and SVCREQ (6) read 0. A SVCREQ write with any other code in bits [4:0] is stored as written and starts no reset, even while lanes are pending.
- R7: A soft reset clears every channel of every group in both directions. The cycle after the request, every bit of `tx_pend` and `rx_pend` is 1.
- R8: A lane's pending flag stays set while its serial clock is stopped or has given only one edge. It clears after that clock runs, within eight serial edges plus eight host cycles. No other lane is affected.
- R9: An activation request (`act_on`=1; lane = `act_dir` 0 transmit / 1 receive, group `act_grp`) on a pending lane is ignored. Once the lane is idle, the request sets the channel, and `act_on`=0 clears it.
- R10: A soft reset request made while lanes are pending keeps them pending. They clear only once their serial clocks run again.
- R11: Each `irq_push` advances `iq_idx` by one, wrapping to 0 after it equals IQLEN. It increments the ISTAT count and sets the wrap flag on wrap. A soft reset posts nothing, so `iq_idx` and the count stay 0.
- R12: `all_idle` is 1 exactly when no lane is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host bus clock |
| rst_n | input | 1 | Host bus reset, active low; also starts a soft reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| irq_push | input | 1 | One interrupt descriptor posted to the queue |
| act_req | input | 1 | Channel activation/deactivation request |
| act_on | input | 1 | 1 activates, 0 deactivates |
| act_dir | input | 1 | 0 transmit, 1 receive |
| act_grp | input | GW | Group of the request |
| act_ch | input | CW | Channel of the request |
| sel_dir | input | 1 | Direction selected for `chan_act_o` |
| sel_grp | input | GW | Group selected for `chan_act_o` |
| chan_act_o | output | NCH | Active channels of the selected lane |
| iq_idx | output | IDXW | Interrupt queue write index |
| tx_sclk | input | NGRP | Transmit serial clocks, one per group |
| rx_sclk | input | NGRP | Receive serial clocks, one per group |
| tx_pend | output | NGRP | Transmit deactivation pending, per group |
| rx_pend | output | NGRP | Receive deactivation pending, per group |
| all_idle | output | 1 | No lane pending |

## Verification
A kept or preset field that goes wrong shows on the first register read one host cycle after the request. The same holds for a queue index that fails to return to zero. A lane handshake that loses its request leaves that lane's pending bit high forever. It also holds `all_idle` low and blocks activation of that lane, which is visible within a few serial edges. A handshake that completes early drops the pending bit while the serial clock is still stopped or has given one edge, and a later activation request then takes effect. Sweeping every lane in turn with only its own serial clock running shows any crossed lane wiring at once.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam logic [3:0] A_GCFG    = 4'd0;
  localparam logic [3:0] A_ISTAT   = 4'd1;
  localparam logic [3:0] A_GRPCFG  = 4'd2;
  localparam logic [3:0] A_PORTCFG = 4'd3;
  localparam logic [3:0] A_MEMPROT = 4'd4;
  localparam logic [3:0] A_MSGLEN  = 4'd5;
  localparam logic [3:0] A_SVCREQ  = 4'd6;
  localparam logic [3:0] A_IQPTR   = 4'd7;
  localparam logic [3:0] A_IQLEN   = 4'd8;

  localparam logic [4:0] SRST_CODE = 5'h11;
  localparam int MASK_COFA_BIT = 4;
  localparam int MASK_OOF_BIT  = 5;

  // Service request opcode decode
  function automatic logic is_srst(input logic [4:0] op);
    return op == SRST_CODE;
  endfunction

  // Global config after soft reset: only the port map survives
  function automatic logic [31:0] gcfg_on_srst(input logic [1:0] portmap);
    return {30'd0, portmap};
  endfunction

  // Group config after soft reset: both masks set, everything else off
  function automatic logic [31:0] grpcfg_on_srst();
    logic [31:0] v;
    v = '0;
    v[MASK_COFA_BIT] = 1'b1;
    v[MASK_OOF_BIT]  = 1'b1;
    return v;
  endfunction

  // Queue write index step: wraps to zero after reaching the limit
  function automatic logic [15:0] idx_next(input logic [15:0] idx, input logic [15:0] lim);
    return (idx >= lim) ? 16'd0 : idx + 16'd1;
  endfunction
endpackage

// File: rtl/srst_regs.sv
module srst_regs
  import srst_pkg::*;
#(
  parameter int IDXW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [31:0]     wr_data,
  input  logic [3:0]      rd_addr,
  output logic [31:0]     rd_data,
  input  logic            irq_push,
  output logic            trig,
  output logic [IDXW-1:0] iq_idx
);
  localparam int PADW = 15 - IDXW;

  logic [31:0]     gcfg, grpcfg, portcfg, memprot, msglen, svcreq, iqptr, iqlen;
  logic [IDXW-1:0] idx_q;
  logic [15:0]     icnt;
  logic            ifull;
  logic [15:0]     idx_step;

  assign trig     = wr_en && (wr_addr == A_SVCREQ) && is_srst(wr_data[4:0]);
  assign idx_step = idx_next(16'(idx_q), 16'(iqlen[IDXW-1:0]));
  assign iq_idx   = idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gcfg    <= '0;
      grpcfg  <= grpcfg_on_srst();
      portcfg <= '0;
      memprot <= '0;
      msglen  <= '0;
      svcreq  <= '0;
      iqptr   <= '0;
      iqlen   <= '0;
      idx_q   <= '0;
      icnt    <= '0;
      ifull   <= 1'b0;
    end else if (trig) begin
      gcfg    <= gcfg_on_srst(gcfg[1:0]);
      grpcfg  <= grpcfg_on_srst();
      portcfg <= '0;
      memprot <= '0;
      msglen  <= '0;
      svcreq  <= '0;
      idx_q   <= '0;
      icnt    <= '0;
      ifull   <= 1'b0;
    end else begin
      if (wr_en) begin
        case (wr_addr)
          A_GCFG:    gcfg    <= wr_data;
          A_GRPCFG:  grpcfg  <= wr_data;
          A_PORTCFG: portcfg <= wr_data;
          A_MEMPROT: memprot <= wr_data;
          A_MSGLEN:  msglen  <= wr_data;
          A_SVCREQ:  svcreq  <= wr_data;
          A_IQPTR:   iqptr   <= wr_data;
          A_IQLEN:   iqlen   <= wr_data;
          default: ;
        endcase
      end
      if (irq_push) begin
        idx_q <= IDXW'(idx_step);
        if (icnt != 16'hFFFF) icnt <= icnt + 16'd1;
        if (idx_step == 16'd0) ifull <= 1'b1;
      end
    end
  end

  always_comb begin
    case (rd_addr)
      A_GCFG:    rd_data = gcfg;
      A_ISTAT:   rd_data = {ifull, {PADW{1'b0}}, idx_q, icnt};
      A_GRPCFG:  rd_data = grpcfg;
      A_PORTCFG: rd_data = portcfg;
      A_MEMPROT: rd_data = memprot;
      A_MSGLEN:  rd_data = msglen;
      A_SVCREQ:  rd_data = svcreq;
      A_IQPTR:   rd_data = iqptr;
      A_IQLEN:   rd_data = iqlen;
      default:   rd_data = '0;
    endcase
  end

  a_r2_portmap_kept: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (gcfg[1:0] == $past(gcfg[1:0])) && (gcfg[31:2] == '0));
  a_r3_status_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (icnt == '0) && !ifull && (idx_q == '0));
  a_r4_group_masks: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> grpcfg[MASK_COFA_BIT] && grpcfg[MASK_OOF_BIT] && (grpcfg[1:0] == 2'b00));
  a_r5_queue_kept: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> $stable(iqptr) && $stable(iqlen));
  a_r6_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> (portcfg == '0) && (memprot == '0) && (msglen == '0) && (svcreq == '0));
endmodule

// File: rtl/srst_lane.sv
module srst_lane #(
  parameter int EDGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic sclk,
  output logic pend
);
  localparam int CNTW = $clog2(EDGES + 1);
  localparam logic [CNTW-1:0] CNT_LAST = CNTW'(EDGES - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(EDGES);

  logic req_q, again_q, ah1, ah2, done;
  logic rs1, rs2, ack_s;
  logic [CNTW-1:0] cnt;

  assign done = req_q & ah2;

  // Host side: pending flag, request level and re-arm on a repeat request
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b1;
      req_q   <= 1'b0;
      again_q <= 1'b0;
    end else if (done) begin
      req_q   <= 1'b0;
      pend    <= again_q | trig;
      again_q <= 1'b0;
    end else begin
      if (trig) begin
        pend <= 1'b1;
        if (req_q) again_q <= 1'b1;
      end
      if (pend && !req_q && !ah2) req_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {ah2, ah1} <= 2'b00;
    else        {ah2, ah1} <= {ah1, ack_s};
  end

  // Serial side: synchronise the request, count edges, return an ack level
  always_ff @(posedge sclk or negedge rst_n) begin
    if (!rst_n) begin
      rs1   <= 1'b0;
      rs2   <= 1'b0;
      cnt   <= '0;
      ack_s <= 1'b0;
    end else begin
      rs1 <= req_q;
      rs2 <= rs1;
      if (!rs2) begin
        cnt   <= '0;
        ack_s <= 1'b0;
      end else begin
        if (cnt != CNT_FULL) cnt <= cnt + 1'b1;
        ack_s <= (cnt >= CNT_LAST);
      end
    end
  end

  a_r8_hold_until_done: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !done) |=> pend);
  a_r8_done_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> pend);
  a_r10_request_sets_pend: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> pend);
endmodule

// File: rtl/srst_chan.sv
module srst_chan #(
  parameter int NGRP = 4,
  parameter int NCH  = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     trig,
  input  logic [2*NGRP-1:0]        pend,
  input  logic                     act_req,
  input  logic                     act_on,
  input  logic                     act_dir,
  input  logic [$clog2(NGRP)-1:0]  act_grp,
  input  logic [$clog2(NCH)-1:0]   act_ch,
  input  logic                     sel_dir,
  input  logic [$clog2(NGRP)-1:0]  sel_grp,
  output logic [NCH-1:0]           chan_act_o
);
  localparam int GW = $clog2(NGRP);
  localparam int NL = 2 * NGRP;
  localparam int LW = GW + 1;

  logic [NCH-1:0] tbl [NL];
  logic [LW-1:0]  act_lane, sel_lane;
  logic           act_ok;

  assign act_lane   = {act_dir, act_grp};
  assign sel_lane   = {sel_dir, sel_grp};
  assign act_ok     = act_req && !pend[act_lane];
  assign chan_act_o = tbl[sel_lane];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NL; l++) tbl[l] <= '0;
    end else if (trig) begin
      for (int l = 0; l < NL; l++) tbl[l] <= '0;
    end else if (act_ok) begin
      tbl[act_lane][act_ch] <= act_on;
    end
  end

  for (genvar l = 0; l < NL; l++) begin : g_lane_chk
    a_r9_no_activate_pending: assert property (@(posedge clk) disable iff (!rst_n)
      pend[l] |=> ((tbl[l] & ~$past(tbl[l])) == '0));
    a_r7_all_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      trig |=> (tbl[l] == '0));
  end
endmodule

// File: rtl/soft_reset_seq.sv
module soft_reset_seq #(
  parameter int NGRP       = 4,
  parameter int NCH        = 32,
  parameter int IDXW       = 8,
  parameter int SCLK_EDGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [3:0]               wr_addr,
  input  logic [31:0]              wr_data,
  input  logic [3:0]               rd_addr,
  output logic [31:0]              rd_data,
  input  logic                     irq_push,
  input  logic                     act_req,
  input  logic                     act_on,
  input  logic                     act_dir,
  input  logic [$clog2(NGRP)-1:0]  act_grp,
  input  logic [$clog2(NCH)-1:0]   act_ch,
  input  logic                     sel_dir,
  input  logic [$clog2(NGRP)-1:0]  sel_grp,
  output logic [NCH-1:0]           chan_act_o,
  output logic [IDXW-1:0]          iq_idx,
  input  logic [NGRP-1:0]          tx_sclk,
  input  logic [NGRP-1:0]          rx_sclk,
  output logic [NGRP-1:0]          tx_pend,
  output logic [NGRP-1:0]          rx_pend,
  output logic                     all_idle
);
  localparam int NL = 2 * NGRP;

  logic              trig;
  logic [NL-1:0]     lane_sclk;
  logic [NL-1:0]     pend_vec;

  assign lane_sclk = {rx_sclk, tx_sclk};
  assign tx_pend   = pend_vec[NGRP-1:0];
  assign rx_pend   = pend_vec[NL-1:NGRP];
  assign all_idle  = ~|pend_vec;

  srst_regs #(.IDXW(IDXW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_push(irq_push), .trig(trig), .iq_idx(iq_idx)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lane
    srst_lane #(.EDGES(SCLK_EDGES)) u_lane (
      .clk(clk), .rst_n(rst_n), .trig(trig), .sclk(lane_sclk[l]), .pend(pend_vec[l])
    );
  end

  srst_chan #(.NGRP(NGRP), .NCH(NCH)) u_chan (
    .clk(clk), .rst_n(rst_n), .trig(trig), .pend(pend_vec),
    .act_req(act_req), .act_on(act_on), .act_dir(act_dir), .act_grp(act_grp), .act_ch(act_ch),
    .sel_dir(sel_dir), .sel_grp(sel_grp), .chan_act_o(chan_act_o)
  );

  a_r12_idle_falls_on_request: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> !all_idle);
endmodule

// File: tb/soft_reset_seq_bench.sv
`timescale 1ns/1ps
module soft_reset_seq_bench;
  localparam int NGRP = 4, NCH = 32, IDXW = 8, NL = 8, GW = 2, CW = 5;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, irq_push = 0, act_req = 0, act_on = 0, act_dir = 0, sel_dir = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [31:0] wr_data = 0, rd_data;
  logic [GW-1:0] act_grp = 0, sel_grp = 0;
  logic [CW-1:0] act_ch = 0;
  logic [NCH-1:0] chan_act_o;
  logic [IDXW-1:0] iq_idx;
  logic [NGRP-1:0] tx_sclk = 0, rx_sclk = 0, tx_pend, rx_pend;
  logic all_idle;
  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_pend;

  always #2.5 clk = ~clk;

  soft_reset_seq u_soft_reset_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .irq_push(irq_push), .act_req(act_req),
    .act_on(act_on), .act_dir(act_dir), .act_grp(act_grp), .act_ch(act_ch),
    .sel_dir(sel_dir), .sel_grp(sel_grp), .chan_act_o(chan_act_o), .iq_idx(iq_idx),
    .tx_sclk(tx_sclk), .rx_sclk(rx_sclk), .tx_pend(tx_pend), .rx_pend(rx_pend),
    .all_idle(all_idle)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_reg(input string tag, input logic [3:0] a, input logic [31:0] exp);
    rd_addr = a; #1;
    chk(tag, rd_data, exp);
  endtask

  task automatic chk_chan(input string tag, input int l, input logic [31:0] exp);
    sel_dir = 1'(l / NGRP); sel_grp = GW'(l % NGRP); #1;
    chk(tag, 32'(chan_act_o), exp);
  endtask

  task automatic chk_pend(input string tag);
    #1;
    chk(tag, 32'({rx_pend, tx_pend}), 32'(exp_pend));
    chk({tag, " idle"}, 32'(all_idle), 32'(exp_pend == 8'h00));
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic act(input int l, input int ch, input logic on);
    @(negedge clk);
    act_req = 1; act_dir = 1'(l / NGRP); act_grp = GW'(l % NGRP); act_ch = CW'(ch); act_on = on;
    @(negedge clk); act_req = 0;
  endtask

  task automatic pulse(input int l, input int n);
    repeat (n) begin
      if (l < NGRP) tx_sclk[l] = 1; else rx_sclk[l - NGRP] = 1;
      #3;
      if (l < NGRP) tx_sclk[l] = 0; else rx_sclk[l - NGRP] = 0;
      #3;
    end
  endtask

  task automatic pulse_all(input int n);
    repeat (n) begin
      tx_sclk = '1; rx_sclk = '1; #3;
      tx_sclk = '0; rx_sclk = '0; #3;
    end
  endtask

  function automatic logic [31:0] pattern(input int l);
    logic [31:0] v = '0;
    for (int ch = 0; ch < NCH; ch++) if ((ch + l) % 3 == 0) v[ch] = 1'b1;
    return v;
  endfunction

  initial begin
    #750000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R1: bus reset state
    idle(3);
    #1;
    exp_pend = 8'hFF;
    chk_pend("R1 pend during reset");
    @(negedge clk); rst_n = 1;
    idle(2);
    for (int a = 0; a <= 8; a++)
      chk_reg($sformatf("R1 reg %0d after reset", a), 4'(a), (a == 2) ? 32'h30 : 32'h0);
    chk("R1 iq_idx", 32'(iq_idx), 32'h0);
    for (int l = 0; l < NL; l++) chk_chan("R1 chan", l, 32'h0);
    chk_pend("R1 pend after reset");

    // R9: activation while pending is ignored; R8/R12: clocks clear pending
    act(0, 3, 1);
    chk_chan("R9 act ignored while pending", 0, 32'h0);
    pulse_all(8); idle(8);
    exp_pend = 8'h00;
    chk_pend("R8 cleared after clocks");

    // R6: ordinary writes stored, non-reset service code
    wr(4'd0, 32'hDEADBEEF); wr(4'd2, 32'h0000000F); wr(4'd3, 32'h00001234);
    wr(4'd4, 32'h000055AA); wr(4'd5, 32'h00000600); wr(4'd7, 32'h10000040);
    wr(4'd8, 32'h00000005); wr(4'd6, 32'h00000203);
    chk_reg("R6 svcreq other code stored", 4'd6, 32'h00000203);
    chk_reg("R6 portcfg stored", 4'd3, 32'h00001234);
    chk_pend("R6 other code no reset");

    // R11: interrupt queue index sweep with IQLEN=5
    for (int i = 1; i <= 13; i++) begin
      @(negedge clk); irq_push = 1; @(negedge clk); irq_push = 0;
      chk($sformatf("R11 iq_idx push %0d", i), 32'(iq_idx), 32'(i % 6));
      chk_reg($sformatf("R3 istat push %0d", i), 4'd1,
              {(i >= 6) ? 1'b1 : 1'b0, 15'(i % 6), 16'(i)});
    end

    // R9: activation on idle lanes, then a deactivation
    for (int l = 0; l < NL; l++)
      for (int ch = 0; ch < NCH; ch++)
        if ((ch + l) % 3 == 0) act(l, ch, 1);
    for (int l = 0; l < NL; l++) chk_chan($sformatf("R9 lane %0d pattern", l), l, pattern(l));
    act(2, 1, 0);
    chk_chan("R9 deactivate", 2, pattern(2) & ~32'h2);

    // R2..R7, R11: soft reset request
    wr(4'd6, 32'hABCDEF11);
    exp_pend = 8'hFF;
    chk_pend("R7 pend after request");
    chk_reg("R2 gcfg port map kept", 4'd0, 32'h00000003);
    chk_reg("R3 istat cleared", 4'd1, 32'h0);
    chk_reg("R4 grpcfg masks", 4'd2, 32'h00000030);
    chk_reg("R6 portcfg cleared", 4'd3, 32'h0);
    chk_reg("R6 memprot cleared", 4'd4, 32'h0);
    chk_reg("R6 msglen cleared", 4'd5, 32'h0);
    chk_reg("R6 svcreq cleared", 4'd6, 32'h0);
    chk_reg("R5 iqptr kept", 4'd7, 32'h10000040);
    chk_reg("R5 iqlen kept", 4'd8, 32'h00000005);
    chk("R11 no descriptor posted", 32'(iq_idx), 32'h0);
    for (int l = 0; l < NL; l++) chk_chan($sformatf("R7 lane %0d dropped", l), l, 32'h0);

    // R6: other service code accepted while pending
    wr(4'd6, 32'h00000007);
    chk_reg("R6 svcreq during pending", 4'd6, 32'h00000007);
    chk_pend("R6 pend unchanged");

    // R8/R9/R12: per-lane sweep, only that lane's clock runs
    for (int l = 0; l < NL; l++) begin
      act(l, l, 1);
      chk_chan($sformatf("R9 lane %0d ignored", l), l, 32'h0);
      idle(3);
      pulse(l, 1); idle(10);
      chk_pend($sformatf("R8 lane %0d one edge", l));
      pulse(l, 8); idle(8);
      exp_pend[l] = 1'b0;
      chk_pend($sformatf("R8 lane %0d cleared", l));
      act(l, l, 1);
      chk_chan($sformatf("R9 lane %0d active", l), l, 32'(1) << l);
    end

    // R10: repeat request while pending
    wr(4'd6, 32'h00000011);
    exp_pend = 8'hFF;
    idle(4); pulse_all(3);
    wr(4'd6, 32'h00000011);
    idle(10);
    chk_pend("R10 still pending after repeat");
    repeat (4) begin pulse_all(8); idle(8); end
    exp_pend = 8'h00;
    chk_pend("R10 cleared after clocks");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule